// File: doc/BRIEF.md
# Radio Time-Code Frame Classifier

This block sits behind the envelope demodulator of a longwave time-signal receiver. It watches the clean, synchronous carrier level, where 1 means carrier present and 0 means carrier off. Each second of the time code begins with the carrier switching off, and the length of that off interval identifies the frame. The block measures the off interval in clock cycles. When the carrier returns it sorts the frame into one of three kinds: a data frame with bit A clear, a data frame with bit A set, or the minute marker.

Three registered outputs carry the result: the latest bit A, a new-minute flag, and a toggle that changes level once for every classified frame. A slow software poller can compare the toggle against its last reading and see that a new frame has arrived, without catching a short pulse. The off-interval limits are given in milliseconds and scaled by a clocks-per-millisecond parameter, so the same code runs on a slowed simulation clock and on the real board clock.

Top module: `msf_frame_decoder`

## Requirements
- R1: While `rstN` is low, `bitA`, `newMinute` and `frameToggle` are all 0. Reset also returns the decoder to waiting for the carrier to be high.
- R2: The off interval is the number of consecutive clock edges that sample `carrierLvl` low after a high-to-low transition. Classification happens on the first edge that samples `carrierLvl` high again, and all outputs take their new values on that same edge. Outputs never change on an edge that samples `carrierLvl` low.
- R3: An off interval shorter than the glitch limit (50 ms of ticks) is discarded, and all three outputs keep their values.
- R4: An off interval that is at least the glitch limit but shorter than the one-limit (150 ms of ticks) sets `bitA` to 0, clears `newMinute` and inverts `frameToggle`.
- R5: An off interval that is at least the one-limit but shorter than the marker limit (350 ms of ticks) sets `bitA` to 1, clears `newMinute` and inverts `frameToggle`.
- R6: An off interval of at least the marker limit sets `newMinute` to 1, leaves `bitA` unchanged and inverts `frameToggle`. This holds for intervals of any length, including intervals far above the limit.
- R7: Each limit in ticks equals its millisecond value multiplied by the `CLK_PER_MS` parameter.
- R8: A low level present when reset is released, or one that began before reset was released, is not measured as a frame. Only a high-to-low transition seen after reset starts a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| carrierLvl | input | 1 | Synchronous demodulated carrier level, 1 = carrier on |
| bitA | output | 1 | Bit A of the most recent data frame |
| newMinute | output | 1 | 1 when the most recent frame was the minute marker |
| frameToggle | output | 1 | Inverts once for every classified frame |

## Verification
The bench builds the block with `CLK_PER_MS` = 2. This places the limits at 100, 300 and 700 cycles, so a run of a few thousand cycles reaches every limit. Off intervals of exactly one cycle below and exactly at each limit are driven, and this pins down every comparison edge. A 3000-cycle off interval drives the saturating counter well past the marker limit. Reset is asserted in the middle of an off interval, and reset is released while the carrier is low, to test the rule that a frame must start with a transition.

// File: rtl/msf_dec_pkg.sv
package msf_dec_pkg;

  // Off-interval limits in milliseconds
  localparam int GLITCH_MS = 50;
  localparam int ONE_MS    = 150;
  localparam int MARK_MS   = 350;

  typedef enum logic [1:0] {
    ST_WAIT_HIGH = 2'd0,
    ST_ARMED     = 2'd1,
    ST_LOW       = 2'd2
  } decState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startCnt;   // first low sample: load counter with 1
    logic incCnt;     // further low sample: count up
    logic latchData;  // classify as a data frame
    logic latchMark;  // classify as the minute marker
  } decCtl_t;

endpackage

// File: rtl/msf_dec_datapath.sv
module msf_dec_datapath
  import msf_dec_pkg::*;
#(
  parameter int CLK_PER_MS = 50000
) (
  input  logic    clk,
  input  logic    rstN,
  input  decCtl_t ctl,
  output logic    geGlitch,
  output logic    geMark,
  output logic    bitA,
  output logic    newMinute,
  output logic    frameToggle
);

  localparam int GLITCH_TICKS = GLITCH_MS * CLK_PER_MS;
  localparam int ONE_TICKS    = ONE_MS * CLK_PER_MS;
  localparam int MARK_TICKS   = MARK_MS * CLK_PER_MS;
  localparam int CNT_W        = $clog2(MARK_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MARK_TICKS);

  logic [CNT_W-1:0] lowCnt;
  logic             geOne;

  // The counter saturates at the marker limit; longer intervals classify the same way
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (ctl.startCnt) begin
      lowCnt <= CNT_W'(1);
    end else if (ctl.incCnt && (lowCnt != CNT_MAX)) begin
      lowCnt <= lowCnt + CNT_W'(1);
    end
  end

  assign geGlitch = (lowCnt >= CNT_W'(GLITCH_TICKS));
  assign geOne    = (lowCnt >= CNT_W'(ONE_TICKS));
  assign geMark   = (lowCnt >= CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitA        <= 1'b0;
      newMinute   <= 1'b0;
      frameToggle <= 1'b0;
    end else if (ctl.latchData) begin
      bitA        <= geOne;
      newMinute   <= 1'b0;
      frameToggle <= ~frameToggle;
    end else if (ctl.latchMark) begin
      newMinute   <= 1'b1;
      frameToggle <= ~frameToggle;
    end
  end

endmodule

// File: rtl/msf_dec_control.sv
module msf_dec_control
  import msf_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    carrierLvl,
  input  logic    geGlitch,
  input  logic    geMark,
  output decCtl_t ctl
);

  decState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT_HIGH;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_WAIT_HIGH: if (carrierLvl) stateNext = ST_ARMED;
      ST_ARMED: begin
        if (!carrierLvl) begin
          stateNext    = ST_LOW;
          ctl.startCnt = 1'b1;
        end
      end
      ST_LOW: begin
        if (!carrierLvl) begin
          ctl.incCnt = 1'b1;
        end else begin
          stateNext = ST_ARMED;
          if (geGlitch) begin
            ctl.latchMark = geMark;
            ctl.latchData = ~geMark;
          end
        end
      end
      default: stateNext = ST_WAIT_HIGH;
    endcase
  end

endmodule

// File: rtl/msf_frame_decoder.sv
module msf_frame_decoder #(
  parameter int CLK_PER_MS = 50000
) (
  input  logic clk,
  input  logic rstN,
  input  logic carrierLvl,
  output logic bitA,
  output logic newMinute,
  output logic frameToggle
);

  msf_dec_pkg::decCtl_t ctl;
  logic geGlitch;
  logic geMark;

  msf_dec_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .carrierLvl (carrierLvl),
    .geGlitch   (geGlitch),
    .geMark     (geMark),
    .ctl        (ctl)
  );

  msf_dec_datapath #(.CLK_PER_MS(CLK_PER_MS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .geGlitch    (geGlitch),
    .geMark      (geMark),
    .bitA        (bitA),
    .newMinute   (newMinute),
    .frameToggle (frameToggle)
  );

endmodule

// File: rtl/msf_dec_checker.sv
module msf_dec_checker (
  input logic clk,
  input logic rstN,
  input logic carrierLvl,
  input logic bitA,
  input logic newMinute,
  input logic frameToggle
);

  // R1: an edge that sees reset leaves every output at zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!bitA && !newMinute && !frameToggle));

  // R2: nothing changes on an edge that samples the carrier low
  assert_hold_while_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !carrierLvl |=> $stable({bitA, newMinute, frameToggle}));

  // R4, R5: a change of bit A belongs to a data frame
  assert_bit_change_is_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bitA) |-> (!newMinute && !$stable(frameToggle)));

  // R6: a marker flips the toggle and leaves bit A alone
  assert_marker_keeps_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (newMinute && !$stable(frameToggle)) |-> $stable(bitA));

  // R6: the new-minute flag rises only together with a toggle flip
  assert_marker_flips_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(newMinute) |-> !$stable(frameToggle));

endmodule

bind msf_frame_decoder msf_dec_checker u_chk (.*);

// File: tb/msf_frame_decoder_tb.sv
module msf_frame_decoder_tb;

  localparam int CPM    = 2;
  localparam int G_TK   = 50 * CPM;
  localparam int ONE_TK = 150 * CPM;
  localparam int MK_TK  = 350 * CPM;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic carrierLvl = 1'b0;
  logic bitA, newMinute, frameToggle;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int mState = 0;   // 0 wait-high, 1 armed, 2 low
  int mCnt = 0;
  logic mA = 0, mM = 0, mT = 0;
  logic expT = 0;

  always #5 clk = ~clk;

  msf_frame_decoder #(.CLK_PER_MS(CPM)) u_dut (
    .clk(clk), .rstN(rstN), .carrierLvl(carrierLvl),
    .bitA(bitA), .newMinute(newMinute), .frameToggle(frameToggle)
  );

  // Behavioural model from R1-style rules (R2..R8), updated each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mCnt = 0; mA = 0; mM = 0; mT = 0;
    end else if (mState == 0) begin
      if (carrierLvl) mState = 1;
    end else if (mState == 1) begin
      if (!carrierLvl) begin mState = 2; mCnt = 1; end
    end else begin
      if (!carrierLvl) mCnt++;
      else begin
        mState = 1;
        if (mCnt >= MK_TK) begin mM = 1; mT = ~mT; end
        else if (mCnt >= G_TK) begin mA = (mCnt >= ONE_TK); mM = 0; mT = ~mT; end
      end
    end
  end

  // Per-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      vectors++;
      if ({bitA, newMinute, frameToggle} !== {mA, mM, mT}) begin
        errors++;
        $display("FAIL R2 model compare at cycle %0d: actual A/M/T=%b%b%b expected %b%b%b",
                 cycles, bitA, newMinute, frameToggle, mA, mM, mT);
      end
    end
  end

  task automatic check(input logic eA, input logic eM, input logic eT, input string tag);
    vectors++;
    if ({bitA, newMinute, frameToggle} !== {eA, eM, eT}) begin
      errors++;
      $display("FAIL %s: actual A/M/T=%b%b%b expected %b%b%b",
               tag, bitA, newMinute, frameToggle, eA, eM, eT);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Low for n cycles, then high; check on the first negedge after the high sample (R2)
  task automatic frame(input int n, input logic eA, input logic eM, input logic flips, input string tag);
    @(negedge clk); carrierLvl = 1'b0;
    idle(n);
    carrierLvl = 1'b1;
    @(negedge clk);
    if (flips) expT = ~expT;
    check(eA, eM, expT, tag);
    idle(20);
  endtask

  initial begin
    carrierLvl = 1'b0;
    idle(5);
    check(1'b0, 1'b0, 1'b0, "R1 reset state");
    rstN = 1'b1;
    idle(150);                     // low since reset: not a frame
    carrierLvl = 1'b1;
    idle(2);
    check(1'b0, 1'b0, 1'b0, "R8 low at reset release ignored");
    idle(30);

    frame(200,  1'b0, 1'b0, 1'b1, "R4 100ms data zero");
    frame(400,  1'b1, 1'b0, 1'b1, "R5 200ms data one");
    frame(G_TK-1, 1'b1, 1'b0, 1'b0, "R3 glitch below limit ignored");
    frame(1000, 1'b1, 1'b1, 1'b1, "R6 marker keeps A=1");
    frame(G_TK, 1'b0, 1'b0, 1'b1, "R4 R7 exactly glitch limit");
    frame(ONE_TK-1, 1'b0, 1'b0, 1'b1, "R4 R7 one below one-limit");
    frame(ONE_TK, 1'b1, 1'b0, 1'b1, "R5 R7 exactly one-limit");
    frame(MK_TK-1, 1'b1, 1'b0, 1'b1, "R5 R7 one below marker limit");
    frame(MK_TK, 1'b1, 1'b1, 1'b1, "R6 R7 exactly marker limit");
    frame(150,  1'b0, 1'b0, 1'b1, "R4 data after marker clears flag");
    frame(1000, 1'b0, 1'b1, 1'b1, "R6 marker keeps A=0");
    frame(3000, 1'b0, 1'b1, 1'b1, "R6 very long low saturates as marker");

    // Reset in the middle of an off interval
    @(negedge clk); carrierLvl = 1'b0;
    idle(50);
    rstN = 1'b0;
    idle(3);
    check(1'b0, 1'b0, 1'b0, "R1 reset mid interval clears outputs");
    rstN = 1'b1;
    expT = 1'b0;
    idle(400);
    carrierLvl = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, 1'b0, "R8 interval cut by reset not classified");
    idle(20);
    frame(400, 1'b1, 1'b0, 1'b1, "R5 first frame after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule